// File: doc/BRIEF.md
# SDRAM Command Timing Enforcer

This block sits between a memory request source and the command bus of a single data rate SDRAM. The requester presents one command per cycle through a valid/ready handshake: row open, row close, column read, column write, or no-operation. Each command carries a bank number and an address. The address holds a row for a row open and a column for a column access. The block issues a command onto a registered command bus only after every applicable spacing rule is met. Until then it holds ready low and drives a no-operation on the bus.

Each rule has its own countdown timer, and the command that came before decides which timers apply. Per bank, the block keeps these timers:

- open-to-column
- open-to-close
- open-to-open
- close-to-open
- write-to-close

Three timers are shared by all banks:

- open-to-open across banks
- column-to-column, sized to the burst length
- write-to-read

The block also records which banks have a row open. Requests that make no sense for the current bank state are accepted, dropped and reported with an error pulse. A read-data-valid strobe is delayed by the CAS latency and then held for one burst.

Top module: `sdram_cmd_gate`

## Requirements
- R1: Command codes on `req_cmd` and `cmd_out` are NOP=0, ACTIVE=1, READ=2, WRITE=3 and PRECHARGE=4. Codes 5 to 7 act as NOP. An accepted legal non-NOP command appears on `cmd_out`, with its bank and address, in the cycle after the clock edge that accepts it. In every other cycle `cmd_out` is 0 and `bank_out` and `addr_out` are 0.
- R2: `req_ready` is high whenever `req_valid` is low. While a valid request is held back by a timer, `req_ready` is low and `cmd_out` shows NOP.
- R3: A READ or WRITE to a bank is accepted no sooner than T_RCD edges after the ACTIVE to that bank.
- R4: An ACTIVE to a bank is accepted no sooner than T_RP edges after the PRECHARGE of that bank.
- R5: A PRECHARGE is accepted no sooner than T_RAS edges after the same bank's ACTIVE. It is also accepted no sooner than T_WR edges after the last WRITE to that bank.
- R6: Two ACTIVEs to the same bank are accepted at least T_RC edges apart.
- R7: Any two ACTIVEs are accepted at least T_RRD edges apart.
- R8: Successive READ or WRITE commands are accepted at least BURST_LEN edges apart. A READ is accepted no sooner than T_WTR edges after the last WRITE.
- R9: The following requests are accepted in the cycle they are presented, with `req_ready` high:
  - a READ, WRITE or PRECHARGE to a closed bank
  - an ACTIVE to an open bank

  The block does not issue them and leaves the bank state unchanged. `err_pulse` is high for exactly the one cycle in which the command would have appeared.
- R10: `rd_valid` is high for BURST_LEN cycles, starting CAS_LAT cycles after a READ appears on `cmd_out`. READs spaced exactly BURST_LEN apart give an unbroken strobe.
- R11: Reset (`rst_n` low) does the following:
  - closes every bank
  - clears every timer
  - drives `cmd_out` to NOP
  - clears `err_pulse` and `rd_valid`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | BANK_W | Target bank |
| req_addr | input | ADDR_W | Row (ACTIVE) or column (READ/WRITE) |
| req_ready | output | 1 | Request accepted at this edge |
| cmd_out | output | 3 | Registered command on the SDRAM bus |
| bank_out | output | BANK_W | Registered bank on the SDRAM bus |
| addr_out | output | ADDR_W | Registered address on the SDRAM bus |
| err_pulse | output | 1 | One-cycle flag for a dropped illegal request |
| rd_valid | output | 1 | Read data valid on the data bus |

## Verification
The assertions assume the requester holds its command, bank and address steady while a request waits. They also assume `BURST_LEN` and `T_RRD` stay below 255, so the checker's saturating gap counters can measure every gap. The bench keeps to this: each request is driven once at a falling edge and held until the handshake completes. Its sweeps use idle gaps of zero to eight cycles with a small timing set in which the write-to-read gap exceeds the burst length. The sweeps therefore land on both sides of each limit, and every rule is observed as the one that binds.

// File: rtl/sdram_gate_pkg.sv
`timescale 1ns/1ps
package sdram_gate_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } sdr_cmd_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
`timescale 1ns/1ps
// Countdown that reports when GAP edges have passed since the last fire.
module sdram_gap_timer #(
    parameter int W   = 4,
    parameter int GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic expired
);
    localparam logic [W-1:0] LOAD_V = W'((GAP > 0) ? GAP - 1 : 0);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [W-1:0] dec;

    always_comb begin
        st_d = st_q;
        dec  = (st_q.cnt == '0) ? '0 : st_q.cnt - 1'b1;
        st_d.cnt = dec;
        // keep the longer of the residual wait and the fresh one
        if (fire && (LOAD_V > dec)) begin
            st_d.cnt = LOAD_V;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = (st_q.cnt == '0);
endmodule

// File: rtl/sdram_bank_tracker.sv
`timescale 1ns/1ps
// Open/closed state and per-bank spacing timers for one bank.
module sdram_bank_tracker #(
    parameter int TW    = 4,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 7,
    parameter int T_RC  = 11,
    parameter int T_WR  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic pre_i,
    input  logic wr_i,
    output logic open_o,
    output logic col_ok_o,
    output logic act_ok_o,
    output logic pre_ok_o
);
    typedef struct packed {
        logic is_open;
    } bank_t;

    bank_t st_d, st_q;
    logic rcd_done, ras_done, rc_done, rp_done, wr_done;

    sdram_gap_timer #(.W(TW), .GAP(T_RCD)) u_rcd (.clk(clk), .rst_n(rst_n), .fire(act_i), .expired(rcd_done));
    sdram_gap_timer #(.W(TW), .GAP(T_RAS)) u_ras (.clk(clk), .rst_n(rst_n), .fire(act_i), .expired(ras_done));
    sdram_gap_timer #(.W(TW), .GAP(T_RC))  u_rc  (.clk(clk), .rst_n(rst_n), .fire(act_i), .expired(rc_done));
    sdram_gap_timer #(.W(TW), .GAP(T_RP))  u_rp  (.clk(clk), .rst_n(rst_n), .fire(pre_i), .expired(rp_done));
    sdram_gap_timer #(.W(TW), .GAP(T_WR))  u_wr  (.clk(clk), .rst_n(rst_n), .fire(wr_i),  .expired(wr_done));

    always_comb begin
        st_d = st_q;
        if (act_i) begin
            st_d.is_open = 1'b1;
        end else if (pre_i) begin
            st_d.is_open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.is_open <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o   = st_q.is_open;
    assign col_ok_o = rcd_done;
    assign act_ok_o = rp_done & rc_done;
    assign pre_ok_o = ras_done & wr_done;
endmodule

// File: rtl/sdram_rd_strobe.sv
`timescale 1ns/1ps
// Delays each accepted READ by CAS latency, then holds valid for one burst.
module sdram_rd_strobe #(
    parameter int CL = 3,
    parameter int BL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    output logic rd_valid_o
);
    localparam int CW = $clog2(BL + 1);

    typedef struct packed {
        logic [CL-1:0] pipe;
        logic [CW-1:0] left;
    } strb_t;

    strb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = rd_i;
        for (int i = 1; i < CL; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        if (st_q.pipe[CL-1]) begin
            st_d.left = CW'(BL);
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pipe <= '0;
            st_q.left <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid_o = (st_q.left != '0);
endmodule

// File: rtl/sdram_cmd_gate.sv
`timescale 1ns/1ps
module sdram_cmd_gate
    import sdram_gate_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int ADDR_W    = 13,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 7,
    parameter int T_RC      = 11,
    parameter int T_RRD     = 3,
    parameter int T_WTR     = 1,
    parameter int T_WR      = 3,
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic [2:0]        cmd_out,
    output logic [BANK_W-1:0] bank_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic              err_pulse,
    output logic              rd_valid
);
    localparam int T_MAX = imax(imax(imax(T_RCD, T_RP), imax(T_RAS, T_RC)),
                                imax(imax(T_RRD, T_WTR), imax(T_WR, BURST_LEN)));
    localparam int TW    = $clog2(T_MAX + 1);

    typedef struct packed {
        sdr_cmd_e          cmd;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic              err;
    } bus_t;

    bus_t st_d, st_q;

    logic [NUM_BANKS-1:0] bank_open, bank_col_ok, bank_act_ok, bank_pre_ok;
    logic [NUM_BANKS-1:0] act_vec, pre_vec, wr_vec;
    logic is_act, is_pre, is_rd, is_wr;
    logic sel_open, illegal, timing_ok, issue;
    logic rrd_ok, ccd_ok, wtr_ok;

    // per-bank state and timers
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign act_vec[b] = issue & is_act & (req_bank == BANK_W'(b));
        assign pre_vec[b] = issue & is_pre & (req_bank == BANK_W'(b));
        assign wr_vec[b]  = issue & is_wr  & (req_bank == BANK_W'(b));

        sdram_bank_tracker #(
            .TW(TW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_WR(T_WR)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act_i(act_vec[b]), .pre_i(pre_vec[b]), .wr_i(wr_vec[b]),
            .open_o(bank_open[b]), .col_ok_o(bank_col_ok[b]),
            .act_ok_o(bank_act_ok[b]), .pre_ok_o(bank_pre_ok[b])
        );
    end

    // timers shared across banks
    sdram_gap_timer #(.W(TW), .GAP(T_RRD)) u_rrd (
        .clk(clk), .rst_n(rst_n), .fire(issue & is_act), .expired(rrd_ok));
    sdram_gap_timer #(.W(TW), .GAP(BURST_LEN)) u_ccd (
        .clk(clk), .rst_n(rst_n), .fire(issue & (is_rd | is_wr)), .expired(ccd_ok));
    sdram_gap_timer #(.W(TW), .GAP(T_WTR)) u_wtr (
        .clk(clk), .rst_n(rst_n), .fire(issue & is_wr), .expired(wtr_ok));

    sdram_rd_strobe #(.CL(CAS_LAT), .BL(BURST_LEN)) u_strobe (
        .clk(clk), .rst_n(rst_n), .rd_i(issue & is_rd), .rd_valid_o(rd_valid));

    always_comb begin
        is_act = 1'b0;
        is_pre = 1'b0;
        is_rd  = 1'b0;
        is_wr  = 1'b0;
        case (req_cmd)
            3'd1:    is_act = 1'b1;
            3'd2:    is_rd  = 1'b1;
            3'd3:    is_wr  = 1'b1;
            3'd4:    is_pre = 1'b1;
            default: ;
        endcase

        sel_open = bank_open[req_bank];
        illegal  = req_valid & ((is_act & sel_open) |
                                ((is_rd | is_wr | is_pre) & ~sel_open));

        if (is_act)      timing_ok = bank_act_ok[req_bank] & rrd_ok;
        else if (is_pre) timing_ok = bank_pre_ok[req_bank];
        else if (is_rd)  timing_ok = bank_col_ok[req_bank] & ccd_ok & wtr_ok;
        else if (is_wr)  timing_ok = bank_col_ok[req_bank] & ccd_ok;
        else             timing_ok = 1'b1;

        issue     = req_valid & ~illegal & timing_ok & (is_act | is_pre | is_rd | is_wr);
        req_ready = ~req_valid | illegal | timing_ok;

        st_d      = st_q;
        st_d.cmd  = CMD_NOP;
        st_d.bank = '0;
        st_d.addr = '0;
        st_d.err  = illegal;
        if (issue) begin
            st_d.cmd  = sdr_cmd_e'(req_cmd);
            st_d.bank = req_bank;
            st_d.addr = req_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cmd  <= CMD_NOP;
            st_q.bank <= '0;
            st_q.addr <= '0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_out   = st_q.cmd;
    assign bank_out  = st_q.bank;
    assign addr_out  = st_q.addr;
    assign err_pulse = st_q.err;
endmodule

// File: rtl/sdram_cmd_gate_checker.sv
`timescale 1ns/1ps
module sdram_cmd_gate_checker #(
    parameter int BL  = 4,
    parameter int RRD = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] cmd_out,
    input logic       err_pulse
);
    logic [7:0] since_col, since_act;
    logic       col_on_bus, act_on_bus;

    assign col_on_bus = (cmd_out == 3'd2) || (cmd_out == 3'd3);
    assign act_on_bus = (cmd_out == 3'd1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_col <= 8'hFF;
            since_act <= 8'hFF;
        end else begin
            if (col_on_bus)            since_col <= 8'd1;
            else if (since_col != 8'hFF) since_col <= since_col + 8'd1;
            if (act_on_bus)            since_act <= 8'd1;
            else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
        end
    end

    a_r2_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> req_ready);

    a_r2_nop_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (cmd_out == 3'd0));

    a_r9_err_means_nop: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (cmd_out == 3'd0));

    a_r9_err_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(req_valid && req_ready));

    a_r8_column_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        col_on_bus |-> (since_col >= 8'(BL)));

    a_r7_active_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        act_on_bus |-> (since_act >= 8'(RRD)));
endmodule

bind sdram_cmd_gate sdram_cmd_gate_checker #(.BL(BURST_LEN), .RRD(T_RRD)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cmd_out(cmd_out), .err_pulse(err_pulse)
);

// File: tb/sdram_cmd_gate_test.sv
`timescale 1ns/1ps
module sdram_cmd_gate_test;
    localparam int B_RCD = 3, B_RP = 3, B_RAS = 7, B_RC = 11, B_RRD = 3;
    localparam int B_WTR = 6, B_WR = 3, B_CL = 3, B_BL = 4;
    localparam int HIST  = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [12:0] req_addr = 13'd0;
    logic        req_ready;
    logic [2:0]  cmd_out;
    logic [1:0]  bank_out;
    logic [12:0] addr_out;
    logic        err_pulse;
    logic        rd_valid;

    int n_chk = 0;
    int n_err = 0;
    int cnt   = 0;
    logic hist [HIST];

    sdram_cmd_gate #(
        .T_RCD(B_RCD), .T_RP(B_RP), .T_RAS(B_RAS), .T_RC(B_RC), .T_RRD(B_RRD),
        .T_WTR(B_WTR), .T_WR(B_WR), .CAS_LAT(B_CL), .BURST_LEN(B_BL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_addr(req_addr), .req_ready(req_ready),
        .cmd_out(cmd_out), .bank_out(bank_out), .addr_out(addr_out),
        .err_pulse(err_pulse), .rd_valid(rd_valid)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;
    always @(negedge clk) if (cnt < HIST) hist[cnt] = rd_valid;

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        req_valid = 1'b0;
        req_cmd   = 3'd0;
        rst_n     = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive at a falling edge, hold until accepted; returns accept edge index
    task automatic send(input int c, input int b, input int a, input bit exp_issue,
                        output int e);
        int  waits;
        bit  stall_bad;
        waits     = 0;
        stall_bad = 1'b0;
        req_cmd   = 3'(c);
        req_bank  = 2'(b);
        req_addr  = 13'(a);
        req_valid = 1'b1;
        #1;
        while (!req_ready && waits < 200) begin
            @(negedge clk);
            waits++;
            if (waits >= 2 && !req_ready && cmd_out != 3'd0) stall_bad = 1'b1;
        end
        if (waits >= 200) chk(1'b0, "R2 watchdog", waits, 0);
        if (waits >= 2) chk(!stall_bad, "R2 nop during stall", 1, 0);
        @(posedge clk);
        e = cnt;
        @(negedge clk);
        req_valid = 1'b0;
        req_cmd   = 3'd0;
        if (exp_issue) begin
            chk(cmd_out == 3'(c), "R1 command", cmd_out, c);
            chk(bank_out == 2'(b) && addr_out == 13'(a), "R1 bank/addr", addr_out, a);
        end else begin
            chk(cmd_out == 3'd0, "R1 nop", cmd_out, 0);
        end
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int e1, e2, e3;
        do_reset();
        // R11 reset state
        #1;
        chk(cmd_out == 3'd0 && err_pulse == 1'b0, "R11 bus idle", cmd_out, 0);
        chk(rd_valid == 1'b0, "R11 strobe low", rd_valid, 0);
        chk(req_ready == 1'b1, "R2 ready idle", req_ready, 1);

        for (int n = 0; n <= 8; n++) begin
            // R3 open-to-column, read and write
            do_reset();
            send(1, n % 4, 100 + n, 1'b1, e1);
            idle(n);
            send((n % 2) ? 3 : 2, n % 4, 8 + n, 1'b1, e2);
            chk(e2 - e1 == mx(B_RCD, n + 1), "R3 gap", e2 - e1, mx(B_RCD, n + 1));

            // R5 open-to-close
            do_reset();
            send(1, 1, 7, 1'b1, e1);
            idle(n);
            send(4, 1, 0, 1'b1, e2);
            chk(e2 - e1 == mx(B_RAS, n + 1), "R5 ras gap", e2 - e1, mx(B_RAS, n + 1));

            // R6 same-bank reopen right after earliest close
            do_reset();
            send(1, 2, 5, 1'b1, e1);
            send(4, 2, 0, 1'b1, e2);
            idle(n);
            send(1, 2, 6, 1'b1, e3);
            chk(e3 - e2 == mx(mx(B_RP, B_RC - B_RAS), n + 1), "R6 rc gap",
                e3 - e2, mx(mx(B_RP, B_RC - B_RAS), n + 1));
            chk(e3 - e1 >= B_RC, "R6 total", e3 - e1, B_RC);

            // R4 close-to-open with open-to-open long satisfied
            do_reset();
            send(1, 3, 5, 1'b1, e1);
            idle(12);
            send(4, 3, 0, 1'b1, e2);
            idle(n);
            send(1, 3, 9, 1'b1, e3);
            chk(e3 - e2 == mx(B_RP, n + 1), "R4 rp gap", e3 - e2, mx(B_RP, n + 1));

            // R7 cross-bank opens
            do_reset();
            send(1, 0, 1, 1'b1, e1);
            idle(n);
            send(1, 1, 2, 1'b1, e2);
            chk(e2 - e1 == mx(B_RRD, n + 1), "R7 rrd gap", e2 - e1, mx(B_RRD, n + 1));

            // R8 read-to-read and write-to-read
            do_reset();
            send(1, 0, 3, 1'b1, e1);
            idle(4);
            send(2, 0, 4, 1'b1, e1);
            idle(n);
            send(2, 0, 8, 1'b1, e2);
            chk(e2 - e1 == mx(B_BL, n + 1), "R8 col gap", e2 - e1, mx(B_BL, n + 1));
            send(3, 0, 12, 1'b1, e1);
            idle(n);
            send(2, 0, 16, 1'b1, e2);
            chk(e2 - e1 == mx(B_WTR, n + 1), "R8 wtr gap", e2 - e1, mx(B_WTR, n + 1));

            // R5 write recovery before close
            do_reset();
            send(1, 2, 3, 1'b1, e1);
            idle(10);
            send(3, 2, 4, 1'b1, e1);
            idle(n);
            send(4, 2, 0, 1'b1, e2);
            chk(e2 - e1 == mx(B_WR, n + 1), "R5 wr gap", e2 - e1, mx(B_WR, n + 1));
        end

        // R10 read strobe, back-to-back and spaced
        for (int g = 0; g <= 6; g += 6) begin
            do_reset();
            send(1, 0, 3, 1'b1, e1);
            idle(3);
            send(2, 0, 0, 1'b1, e1);
            idle(g);
            send(2, 0, 4, 1'b1, e2);
            idle(16);
            for (int k = 0; k < 20; k++) begin
                bit exp_v;
                exp_v = (k >= B_CL && k < B_CL + B_BL) ||
                        (k >= (e2 - e1) + B_CL && k < (e2 - e1) + B_CL + B_BL);
                chk(hist[e1 + 1 + k] == exp_v, "R10 strobe", hist[e1 + 1 + k], exp_v);
            end
        end

        // R9 illegal requests per bank
        for (int b = 0; b < 4; b++) begin
            do_reset();
            send(2, b, 1, 1'b0, e1);
            chk(err_pulse == 1'b1, "R9 read closed", err_pulse, 1);
            idle(1);
            chk(err_pulse == 1'b0, "R9 one cycle", err_pulse, 0);
            send(3, b, 1, 1'b0, e1);
            chk(err_pulse == 1'b1, "R9 write closed", err_pulse, 1);
            send(4, b, 0, 1'b0, e1);
            chk(err_pulse == 1'b1, "R9 close closed", err_pulse, 1);
            send(1, b, 20, 1'b1, e1);
            chk(err_pulse == 1'b0, "R9 legal open", err_pulse, 0);
            idle(12);
            send(1, b, 21, 1'b0, e2);
            chk(err_pulse == 1'b1, "R9 open open", err_pulse, 1);
            chk(e2 - e1 == 13, "R9 accepted at once", e2 - e1, 13);
            send(2, b, 5, 1'b1, e3);
            chk(err_pulse == 1'b0, "R9 bank still open", err_pulse, 0);
        end

        // R1 undefined code treated as NOP
        send(5, 1, 3, 1'b0, e1);
        chk(err_pulse == 1'b0, "R1 code 5 no error", err_pulse, 0);

        // R11 reset closes banks
        do_reset();
        send(1, 0, 1, 1'b1, e1);
        do_reset();
        send(2, 0, 1, 1'b0, e1);
        chk(err_pulse == 1'b1, "R11 bank closed after reset", err_pulse, 1);

        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule